// File: doc/BRIEF.md
# Memory Controller Calibration Scheduler

This block lives in a DDR3-style memory controller. It decides when the memory's output-impedance calibration runs, drives the command pins that start a calibration, and keeps the channel quiet while the device calibrates. Two kinds of calibration exist. A long one corrects process error and large drift. A short one tracks slow voltage and temperature drift.

After reset the scheduler owes the device a long calibration, and it issues that one first. Software or a health monitor can ask for a later long calibration through a request pulse. Short calibrations come from a programmable periodic timer and after every self-refresh exit. A calibration goes out only when all banks are closed, the precharge recovery time since the last precharge has passed, the self-refresh exit recovery time has passed, and the clock enable has been high on the previous cycle and the current one.

While a calibration window runs, the block asserts a busy flag. Busy refuses grants to other command traffic, forces the clock enable high, masks on-die termination and holds the data bus in high impedance. The recovery times and the period arrive as clock-count inputs.

Top module: `imp_cal_sched`

## Requirements
- R1: The first long calibration after reset is followed by INIT_CYC quiet cycles. busy_o is high from the issue cycle through issue+INIT_CYC, so it is high for INIT_CYC+1 cycles.
- R2: Every later long calibration, whether from long_req_i or any other long request, is followed by OPER_CYC quiet cycles, so busy_o is high for OPER_CYC+1 cycles.
- R3: A short calibration drives a10_o=0 and is followed by SHORT_CYC quiet cycles, so busy_o is high for SHORT_CYC+1 cycles. A long calibration drives a10_o=1 in its issue cycle.
- R4: In the issue cycle the pins {cs_n,ras_n,cas_n,we_n} are 4'b0110. On every other cycle, including every quiet cycle, they are NOP, 4'b0111. No calibration is issued while a window is running.
- R5: A calibration is issued only while all_pre_i is high and at least trp_cyc_i cycles after a pre_issued_i pulse. With a pulse at cycle p, the earliest issue is at cycle p+trp_cyc_i.
- R6: A sr_exit_i pulse at cycle e makes a short calibration pending. That calibration is issued no earlier than cycle e+txs_cyc_i.
- R7: With period_cyc_i = P (non-zero), a short calibration becomes due P cycles after the previous issue of either kind. P = 0 disables the periodic timer.
- R8: A due short calibration that is blocked stays pending. It is issued on the first cycle at which the gates open, and the next period is counted from that actual issue.
- R9: While busy_o is high, cke_o=1, odt_o=0 and dq_oe_o=0. While busy_o is low, odt_o follows odt_i and dq_oe_o follows dq_oe_i.
- R10: ext_gnt_o equals ext_req_i while busy_o is low, and is 0 while busy_o is high.
- R11: A calibration is issued only when cke_i was high on the previous cycle and is high in the issue cycle. Inputs are sampled at each rising edge.
- R12: A long request takes priority over a pending short one. Issuing a long calibration also clears any pending short calibration and restarts the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trp_cyc_i | input | CNT_W | Precharge recovery time in cycles |
| txs_cyc_i | input | CNT_W | Self-refresh exit recovery time in cycles |
| period_cyc_i | input | CNT_W | Short-calibration period in cycles (0 disables the timer) |
| all_pre_i | input | 1 | High when all banks are precharged |
| pre_issued_i | input | 1 | Pulse when a precharge command is issued |
| sr_exit_i | input | 1 | Pulse on self-refresh exit |
| long_req_i | input | 1 | Pulse that requests a later long calibration |
| cke_i | input | 1 | Clock enable from the power logic |
| odt_i | input | 1 | Termination enable from the data path |
| dq_oe_i | input | 1 | Data-bus output enable from the data path |
| ext_req_i | input | 1 | Request from other command traffic |
| ext_gnt_o | output | 1 | Grant to other command traffic |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10: 1 selects long, 0 selects short |
| cke_o | output | 1 | Clock enable to the device |
| odt_o | output | 1 | Termination enable to the device |
| dq_oe_o | output | 1 | Data-bus output enable (0 means high impedance) |
| busy_o | output | 1 | Calibration issue or quiet window in progress |

## Verification
Several behaviours are checked by assertions on every cycle. During a busy window the pins must be quiet, no issue may occur inside a running window, every issue must fall on a precharged, clock-enabled cycle clear of precharge and self-refresh-exit pulses, and a due timer must hold until it is restarted. Other behaviours can only be shown by the bench's scenarios. These are the exact window length for each calibration kind, the first-after-reset versus later distinction, the precharge and self-refresh recovery offsets, the periodic spacing and its restart after a blocked period, the clock-enable history rule, and the way a long calibration absorbs a pending short one.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t CMD_CAL = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

  typedef enum logic {
    CAL_SHORT = 1'b0,
    CAL_LONG  = 1'b1
  } cal_kind_e;

endpackage

// File: rtl/imp_cal_hold.sv
// Recovery gate: ok_o rises len_i cycles after a start pulse.
module imp_cal_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             ok_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= (len_i == '0) ? '0 : len_i - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign ok_o = (cnt_q == '0) && !start_i;

endmodule

// File: rtl/imp_cal_timer.sv
// Saturating period timer; due_o holds until restart.
module imp_cal_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             due_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= CNT_W'(1);
    end else if (cnt_q < period_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign due_o = (period_i != '0) && (cnt_q >= period_i);

  p_due_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o && !restart_i && $stable(period_i) |=> due_o);

endmodule

// File: rtl/imp_cal_window.sv
// Quiet-window down-counter.
module imp_cal_window #(
  parameter int WIN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             active_o
);

  logic [WIN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - WIN_W'(1);
    end
  end

  assign active_o = (cnt_q != '0);

  p_no_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !load_i);

endmodule

// File: rtl/imp_cal_sched.sv
module imp_cal_sched
  import imp_cal_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int INIT_CYC  = 512,
  parameter int OPER_CYC  = 256,
  parameter int SHORT_CYC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] trp_cyc_i,
  input  logic [CNT_W-1:0] txs_cyc_i,
  input  logic [CNT_W-1:0] period_cyc_i,
  input  logic             all_pre_i,
  input  logic             pre_issued_i,
  input  logic             sr_exit_i,
  input  logic             long_req_i,
  input  logic             cke_i,
  input  logic             odt_i,
  input  logic             dq_oe_i,
  input  logic             ext_req_i,
  output logic             ext_gnt_o,
  output logic             cs_n_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic             a10_o,
  output logic             cke_o,
  output logic             odt_o,
  output logic             dq_oe_o,
  output logic             busy_o
);

  localparam int WIN_W = $clog2(INIT_CYC + 1);

  logic trp_ok, txs_ok, due, win_active;
  logic first_pend_q, first_done_q, long_pend_q, sr_pend_q, cke_q;
  logic pend_long, pend_short, gate_ok, fire;
  cal_kind_e kind;
  logic [WIN_W-1:0] win_len;
  cmd_pins_t cmd;

  imp_cal_hold #(.CNT_W(CNT_W)) u_trp (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(pre_issued_i), .len_i(trp_cyc_i), .ok_o(trp_ok)
  );

  imp_cal_hold #(.CNT_W(CNT_W)) u_txs (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(sr_exit_i), .len_i(txs_cyc_i), .ok_o(txs_ok)
  );

  imp_cal_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(fire), .period_i(period_cyc_i), .due_o(due)
  );

  imp_cal_window #(.WIN_W(WIN_W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fire), .len_i(win_len), .active_o(win_active)
  );

  assign pend_long  = first_pend_q | long_pend_q | long_req_i;
  assign pend_short = sr_pend_q | due;
  assign gate_ok    = all_pre_i & trp_ok & txs_ok & cke_i & cke_q & ~win_active;
  assign fire       = gate_ok & (pend_long | pend_short);
  assign kind       = pend_long ? CAL_LONG : CAL_SHORT;

  always_comb begin
    if (kind == CAL_LONG) win_len = first_done_q ? WIN_W'(OPER_CYC) : WIN_W'(INIT_CYC);
    else                  win_len = WIN_W'(SHORT_CYC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_pend_q <= 1'b1;
      first_done_q <= 1'b0;
      long_pend_q  <= 1'b0;
      sr_pend_q    <= 1'b0;
      cke_q        <= 1'b0;
    end else begin
      cke_q <= cke_i;
      if (fire && kind == CAL_LONG) begin
        first_pend_q <= 1'b0;
        first_done_q <= 1'b1;
        long_pend_q  <= 1'b0;
      end else if (long_req_i) begin
        long_pend_q <= 1'b1;
      end
      // any issue satisfies an outstanding self-refresh-exit calibration
      if (fire)           sr_pend_q <= 1'b0;
      else if (sr_exit_i) sr_pend_q <= 1'b1;
    end
  end

  assign cmd       = fire ? CMD_CAL : CMD_NOP;
  assign cs_n_o    = cmd.cs_n;
  assign ras_n_o   = cmd.ras_n;
  assign cas_n_o   = cmd.cas_n;
  assign we_n_o    = cmd.we_n;
  assign a10_o     = fire & (kind == CAL_LONG);
  assign busy_o    = fire | win_active;
  assign cke_o     = cke_i | busy_o;
  assign odt_o     = odt_i & ~busy_o;
  assign dq_oe_o   = dq_oe_i & ~busy_o;
  assign ext_gnt_o = ext_req_i & ~busy_o;

  p_cke_hist_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> cke_i && $past(cke_i));

  p_quiet_pins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cke_o && !odt_o && !dq_oe_o);

  p_precharged_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> all_pre_i && !pre_issued_i);

  p_sr_exit_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> !sr_exit_i);

  p_no_back_to_back_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !fire);

endmodule

// File: tb/imp_cal_sched_tb.sv
module imp_cal_sched_tb_top;

  localparam int CNT_W = 16;
  localparam int INIT  = 12;
  localparam int OPER  = 8;
  localparam int SHRT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] trp_cyc = 16'd3, txs_cyc = 16'd5, period_cyc = '0;
  logic all_pre = 1'b0, pre_issued = 1'b0, sr_exit = 1'b0, long_req = 1'b0;
  logic cke = 1'b1, odt = 1'b1, dq_oe = 1'b1, ext_req = 1'b1;
  logic ext_gnt, cs_n, ras_n, cas_n, we_n, a10, cke_out, odt_out, dq_oe_out, busy;

  int checks = 0, errors = 0, cyc = 0;
  int fire_cnt = 0, last_fire_cyc = -1, last_fire_long = -1, last_len = 0, run = 0;
  bit mon_en = 1'b0, done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  imp_cal_sched #(.CNT_W(CNT_W), .INIT_CYC(INIT), .OPER_CYC(OPER), .SHORT_CYC(SHRT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trp_cyc_i(trp_cyc), .txs_cyc_i(txs_cyc),
    .period_cyc_i(period_cyc), .all_pre_i(all_pre), .pre_issued_i(pre_issued),
    .sr_exit_i(sr_exit), .long_req_i(long_req), .cke_i(cke), .odt_i(odt),
    .dq_oe_i(dq_oe), .ext_req_i(ext_req), .ext_gnt_o(ext_gnt), .cs_n_o(cs_n),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .a10_o(a10), .cke_o(cke_out),
    .odt_o(odt_out), .dq_oe_o(dq_oe_out), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic go_to(input int c);
    while (cyc < c) tick(1);
  endtask

  task automatic expect_fire(input string req, input int n, input int at, input int lng, input int len);
    chk({req, " count"}, fire_cnt, n);
    chk({req, " cycle"}, last_fire_cyc, at);
    chk({req, " a10"}, last_fire_long, lng);
    chk({req, " window"}, last_len, len);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // per-cycle port monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (!cs_n && !we_n) begin
        fire_cnt++;
        last_fire_cyc = cyc;
        last_fire_long = int'(a10);
        chk("R4 issue pins", int'({cs_n, ras_n, cas_n, we_n}), 4'b0110);
      end else begin
        chk("R4 nop pins", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
      end
      if (busy) begin
        run++;
        chk("R9 quiet pins", int'({cke_out, odt_out, dq_oe_out}), 3'b100);
        chk("R10 grant blocked", int'(ext_gnt), 0);
      end else begin
        chk("R9 pass-through", int'({odt_out, dq_oe_out}), int'({odt, dq_oe}));
        chk("R10 grant", int'(ext_gnt), int'(ext_req));
        if (run > 0) begin
          last_len = run;
          run = 0;
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    int c, d, e, f, g;
    tick(3);
    // reset state
    chk("R4 reset nop", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset grant", int'(ext_gnt), 1);
    chk("R9 reset odt", int'(odt_out), 1);
    rst_n = 1'b1;
    mon_en = 1'b1;
    tick(6);
    // R5: banks open, nothing issues
    chk("R5 no issue while banks open", fire_cnt, 0);
    c = cyc;
    pre_issued = 1'b1;
    all_pre = 1'b1;
    tick(1);
    pre_issued = 1'b0;
    go_to(c + 3 + INIT + 3);
    expect_fire("R1 R5 first long", 1, c + 3, 1, INIT + 1);

    // R2 later long, R7 periodic short
    d = c + 40;
    go_to(d);
    long_req = 1'b1;
    period_cyc = 16'd20;
    tick(1);
    long_req = 1'b0;
    go_to(d + 15);
    expect_fire("R2 later long", 2, d, 1, OPER + 1);
    go_to(d + 30);
    expect_fire("R3 R7 periodic short", 3, d + 20, 0, SHRT + 1);
    go_to(d + 45);
    expect_fire("R7 second period", 4, d + 40, 0, SHRT + 1);
    all_pre = 1'b0;
    go_to(d + 70);
    chk("R8 pending while banks open", fire_cnt, 4);
    all_pre = 1'b1;
    go_to(d + 80);
    expect_fire("R8 issue on reopen", 5, d + 70, 0, SHRT + 1);
    go_to(d + 95);
    expect_fire("R8 restart from issue", 6, d + 90, 0, SHRT + 1);
    period_cyc = '0;

    // R11 clock-enable history
    e = d + 100;
    go_to(e);
    cke = 1'b0;
    long_req = 1'b1;
    tick(1);
    long_req = 1'b0;
    go_to(e + 3);
    chk("R11 no issue with cke low", fire_cnt, 6);
    cke = 1'b1;
    go_to(e + 4 + OPER + 3);
    expect_fire("R11 issue after cke history", 7, e + 4, 1, OPER + 1);
    chk("R7 period zero disables", fire_cnt, 7);

    // R6 self-refresh exit
    f = e + 20;
    go_to(f);
    sr_exit = 1'b1;
    tick(1);
    sr_exit = 1'b0;
    go_to(f + 5 + SHRT + 3);
    expect_fire("R6 exit short", 8, f + 5, 0, SHRT + 1);

    // R12 long absorbs pending short
    g = f + 15;
    go_to(g);
    all_pre = 1'b0;
    sr_exit = 1'b1;
    tick(1);
    sr_exit = 1'b0;
    long_req = 1'b1;
    tick(1);
    long_req = 1'b0;
    go_to(g + 8);
    all_pre = 1'b1;
    go_to(g + 8 + OPER + 3);
    expect_fire("R12 long first", 9, g + 8, 1, OPER + 1);
    go_to(g + 40);
    chk("R12 short cleared", fire_cnt, 9);

    finish_run();
  end

endmodule